// File: doc/BRIEF.md
# Cassette FSK Tape Writer

This block turns an inclusive range of bytes into a one-bit audio signal for a cassette recorder. The signal is made only of level changes, one at the end of each timed half-cycle. A command gives a first and a last address. The block fetches each byte through a synchronous read port, with one byte returned per address, and sends it out as frequency-keyed cycles. When the last byte has been sent it pulses `done`.

Every transfer starts with a long leader tone. Each leader cycle has a long phase followed by a slightly shorter one. The leader ends with a sync mark made of a clipped phase and then a normal short phase. The data bits follow, most significant bit first. Each bit is one full cycle: a long cycle means one and a short cycle means zero.

All durations are parameters in microseconds. A ticks-per-microsecond parameter scales them to the clock rate, so each phase lasts its microsecond value times that parameter, in clock cycles.

Top module: `tape_fsk_writer`

## Requirements
- R1: After reset `tape_out`, `busy`, `done` and `mem_rd` are all 0.
- R2: The block accepts a command only on a clock edge where `cmd_valid` is high and it is idle. From that edge it sends the leader.
  - The leader is `LEADER_US/(LEAD_LONG_US+LEAD_SHORT_US)` cycles, with a minimum of 1.
  - Each cycle is a phase of `LEAD_LONG_US` followed by a phase of `LEAD_SHORT_US`.
  - The first level change comes `LEAD_LONG_US*TICKS_PER_US` clock cycles after the accepting edge.
- R3: After the leader comes the sync mark: one phase of `MARK_US` and then one phase of `LEAD_SHORT_US`.
- R4: Each data bit is two equal phases: two of `ONE_HALF_US` for a 1, or two of `ZERO_HALF_US` for a 0. Bits go out from bit 7 down to bit 0.
- R5: The bytes go out in ascending address order, starting at `cmd_first`. The block compares the current address with `cmd_last` before it steps to the next one, so the range includes `cmd_last`.
- R6: If `cmd_first` is greater than `cmd_last` (unsigned), exactly one byte is sent: the byte at `cmd_first`.
- R7: `done` is high for one clock cycle, on the same edge as the final level change. `busy` falls on that edge. After that `tape_out` keeps its level while the block is idle.
- R8: A `cmd_valid` pulse that arrives while `busy` is high is ignored and leaves the transfer in progress unchanged.
- R9: Each accepted command gets its own full leader, even when it follows the previous `done` directly.
- R10: `mem_rd` is a one-cycle strobe with `mem_addr` valid in the same cycle. `mem_data` must hold the addressed byte in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe; taken only while idle |
| cmd_first | input | AW | First address of the range |
| cmd_last | input | AW | Last address of the range (inclusive) |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when the range is complete |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_data | input | 8 | Byte returned one cycle after `mem_rd` |
| tape_out | output | 1 | Audio level to the recorder |

## Verification
The hardest case to reach from the ports is a command arriving in the middle of a transfer. It must leave both the address walk and the timing untouched.

The bench injects a foreign range while the second leader phase is still running. It then checks every later interval against the intervals predicted for the original range. Because each byte is recovered from measured toggle intervals, a stray read or a skipped prefetch shows up as a wrong interval.

The bench also covers three range corners: a reversed range, a single-byte range, and a range that ends at the top address. Commands are issued back to back so that the leader of each one is checked directly after the previous `done`.

// File: rtl/tape_fsk_pkg.sv
package tape_fsk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD_A,
    ST_LEAD_B,
    ST_MARK_A,
    ST_MARK_B,
    ST_BIT_A,
    ST_BIT_B
  } wr_state_t;

  // Number of whole leader cycles that fit in the requested leader time.
  function automatic int leader_cycles(input int total_us, input int long_us,
                                       input int short_us);
    int n;
    n = total_us / (long_us + short_us);
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Inclusive-range test, taken before the address steps.
  function automatic logic range_last(input logic [31:0] cur,
                                      input logic [31:0] stop);
    return cur >= stop;
  endfunction

endpackage

// File: rtl/tape_phase_timer.sv
module tape_phase_timer #(
  parameter int TICKS_PER_US = 50,
  parameter int DW           = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] dur_us,
  output logic          expire
);
  localparam int PW = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;

  logic [PW-1:0] presc;
  logic [DW-1:0] remain;
  logic          active;
  logic          us_stb;

  assign us_stb = active && (presc == PW'(TICKS_PER_US - 1));
  assign expire = us_stb && (remain == DW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc  <= '0;
      remain <= '0;
      active <= 1'b0;
    end else if (load) begin
      presc  <= '0;
      remain <= dur_us;
      active <= 1'b1;
    end else if (active) begin
      if (us_stb) begin
        presc  <= '0;
        remain <= remain - DW'(1);
        if (remain == DW'(1)) active <= 1'b0;
      end else begin
        presc <= presc + PW'(1);
      end
    end
  end

  // R2: a running phase never has zero microseconds left
  a_r2_remain_live: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (remain != '0));

endmodule

// File: rtl/tape_addr_walker.sv
module tape_addr_walker #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] first_i,
  input  logic [AW-1:0] last_i,
  input  logic          load_byte,
  input  logic          advance,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic          is_last
);
  import tape_fsk_pkg::*;

  logic [AW-1:0] cur, stop, fetch_next;

  assign is_last = range_last(32'(cur), 32'(stop));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur        <= '0;
      stop       <= '0;
      fetch_next <= '0;
      mem_addr   <= '0;
      mem_rd     <= 1'b0;
    end else if (start_i) begin
      cur        <= first_i;
      stop       <= last_i;
      mem_addr   <= first_i;
      mem_rd     <= 1'b1;
      fetch_next <= first_i + AW'(1);
    end else if (load_byte) begin
      mem_addr   <= fetch_next;
      mem_rd     <= 1'b1;
      fetch_next <= fetch_next + AW'(1);
      if (advance) cur <= cur + AW'(1);
    end else begin
      mem_rd <= 1'b0;
    end
  end

  // R10: read strobe lasts one cycle
  a_r10_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  // R5: the walk only steps while the range is unfinished
  a_r5_no_step_past_end: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> !is_last);

endmodule

// File: rtl/tape_fsk_writer.sv
module tape_fsk_writer #(
  parameter int AW            = 16,
  parameter int TICKS_PER_US  = 50,
  parameter int LEADER_US     = 10_000_000,
  parameter int LEAD_LONG_US  = 565,
  parameter int LEAD_SHORT_US = 455,
  parameter int MARK_US       = 385,
  parameter int ZERO_HALF_US  = 250,
  parameter int ONE_HALF_US   = 500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_first,
  input  logic [AW-1:0] cmd_last,
  output logic          busy,
  output logic          done,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_data,
  output logic          tape_out
);
  import tape_fsk_pkg::*;

  localparam int LEAD_CYC = leader_cycles(LEADER_US, LEAD_LONG_US, LEAD_SHORT_US);
  localparam int LCW      = $clog2(LEAD_CYC + 1);
  localparam int DUR_MAX  = max2(max2(LEAD_LONG_US, LEAD_SHORT_US),
                                 max2(MARK_US, max2(ZERO_HALF_US, ONE_HALF_US)));
  localparam int DW       = $clog2(DUR_MAX + 1);

  wr_state_t     state, state_n;
  logic [LCW-1:0] lead_cnt;
  logic [2:0]    bit_idx;
  logic [7:0]    shreg, nxt_byte;
  logic          rd_q;
  logic [DW-1:0] dur;
  logic          tmr_load, phase_end, accept;
  logic          load_byte, advance, finish, last_byte;

  function automatic logic [DW-1:0] bit_dur(input logic b);
    return b ? DW'(ONE_HALF_US) : DW'(ZERO_HALF_US);
  endfunction

  assign accept = cmd_valid && (state == ST_IDLE);
  assign busy   = (state != ST_IDLE);

  tape_phase_timer #(.TICKS_PER_US(TICKS_PER_US), .DW(DW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .dur_us(dur), .expire(phase_end)
  );

  tape_addr_walker #(.AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .start_i(accept), .first_i(cmd_first),
    .last_i(cmd_last), .load_byte(load_byte), .advance(advance),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .is_last(last_byte)
  );

  always_comb begin
    state_n   = state;
    dur       = '0;
    tmr_load  = 1'b0;
    load_byte = 1'b0;
    advance   = 1'b0;
    finish    = 1'b0;
    unique case (state)
      ST_IDLE: if (cmd_valid) begin
        state_n = ST_LEAD_A; dur = DW'(LEAD_LONG_US); tmr_load = 1'b1;
      end
      ST_LEAD_A: if (phase_end) begin
        state_n = ST_LEAD_B; dur = DW'(LEAD_SHORT_US); tmr_load = 1'b1;
      end
      ST_LEAD_B: if (phase_end) begin
        tmr_load = 1'b1;
        if (lead_cnt == LCW'(LEAD_CYC - 1)) begin
          state_n = ST_MARK_A; dur = DW'(MARK_US);
        end else begin
          state_n = ST_LEAD_A; dur = DW'(LEAD_LONG_US);
        end
      end
      ST_MARK_A: if (phase_end) begin
        state_n = ST_MARK_B; dur = DW'(LEAD_SHORT_US); tmr_load = 1'b1;
      end
      ST_MARK_B: if (phase_end) begin
        state_n = ST_BIT_A; dur = bit_dur(nxt_byte[7]);
        tmr_load = 1'b1; load_byte = 1'b1;
      end
      ST_BIT_A: if (phase_end) begin
        state_n = ST_BIT_B; dur = bit_dur(shreg[7]); tmr_load = 1'b1;
      end
      ST_BIT_B: if (phase_end) begin
        if (bit_idx != 3'd7) begin
          state_n = ST_BIT_A; dur = bit_dur(shreg[6]); tmr_load = 1'b1;
        end else if (last_byte) begin
          state_n = ST_IDLE; finish = 1'b1;
        end else begin
          state_n = ST_BIT_A; dur = bit_dur(nxt_byte[7]);
          tmr_load = 1'b1; load_byte = 1'b1; advance = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      lead_cnt <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      nxt_byte <= '0;
      rd_q     <= 1'b0;
      done     <= 1'b0;
      tape_out <= 1'b0;
    end else begin
      state    <= state_n;
      done     <= finish;
      rd_q     <= mem_rd;
      tape_out <= tape_out ^ phase_end;
      if (rd_q) nxt_byte <= mem_data;
      if (accept) lead_cnt <= '0;
      else if (state == ST_LEAD_B && phase_end) lead_cnt <= lead_cnt + LCW'(1);
      if (load_byte) begin
        shreg   <= nxt_byte;
        bit_idx <= '0;
      end else if (state == ST_BIT_B && phase_end) begin
        shreg   <= {shreg[6:0], 1'b0};
        bit_idx <= bit_idx + 3'd1;
      end
    end
  end

  // R4: level changes only at a timer expiry during a transfer
  a_r4_toggle_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (tape_out != $past(tape_out)) |-> $past(phase_end && busy));
  // R7: done comes with idle
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R7: output level holds while idle
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(tape_out));
  // R8: a command during a transfer does not end it
  a_r8_busy_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && !finish) |=> busy);
  // R6: a transfer finishes only on the last byte of the range
  a_r6_finish_last: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> last_byte);

endmodule

// File: tb/tape_fsk_writer_test.sv
module tape_fsk_writer_test;
  localparam int AW = 8, TPU = 2, LEADER_US = 36, LL = 7, LS = 5, MK = 4,
                 ZH = 3, OH = 6;
  localparam int LC = LEADER_US / (LL + LS);  // 3 leader cycles
  localparam logic [15:0] VEC [4] = '{16'h1010, 16'h2022, 16'h302E, 16'hFEFF};

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [AW-1:0] cmd_first = '0, cmd_last = '0, mem_addr;
  logic busy, done, mem_rd, tape_out;
  logic [7:0] mem_data = '0;
  int checks = 0, fails = 0, cyc = 0;
  int exp_iv [0:1023];

  always #4 clk = ~clk;

  tape_fsk_writer #(.AW(AW), .TICKS_PER_US(TPU), .LEADER_US(LEADER_US),
    .LEAD_LONG_US(LL), .LEAD_SHORT_US(LS), .MARK_US(MK),
    .ZERO_HALF_US(ZH), .ONE_HALF_US(OH)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_first(cmd_first),
    .cmd_last(cmd_last), .busy(busy), .done(done), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_data(mem_data), .tape_out(tape_out));

  function automatic logic [7:0] byte_at(input logic [7:0] a);
    return a * 8'd37 + 8'd5;
  endfunction

  // R10: synchronous memory, data one cycle after the strobe
  always @(posedge clk) if (mem_rd) mem_data <= byte_at(mem_addr);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic run_cmd(input logic [7:0] s, input logic [7:0] e, input bit poke);
    int n = 0, nb, cnt, idx;
    logic prev;
    string tag;
    nb = (e >= s) ? int'(e - s) + 1 : 1;
    for (int i = 0; i < LC; i++) begin
      exp_iv[n++] = LL * TPU; exp_iv[n++] = LS * TPU;
    end
    exp_iv[n++] = MK * TPU; exp_iv[n++] = LS * TPU;
    for (int b = 0; b < nb; b++) begin
      logic [7:0] d;
      d = byte_at(s + 8'(b));
      for (int k = 7; k >= 0; k--) begin
        exp_iv[n++] = (d[k] ? OH : ZH) * TPU;
        exp_iv[n++] = (d[k] ? OH : ZH) * TPU;
      end
    end
    @(negedge clk);
    cmd_first = s; cmd_last = e; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy == 1'b1, "R2 accept busy", busy, 1);
    cnt = 0; idx = 0; prev = tape_out;
    while (idx < n) begin
      @(negedge clk);
      cnt++;
      // R8: foreign command during the leader
      if (poke && idx == 1 && cnt == 1) begin
        cmd_first = 8'h55; cmd_last = 8'h60; cmd_valid = 1'b1;
      end
      if (poke && idx == 1 && cnt == 2) cmd_valid = 1'b0;
      if (tape_out != prev) begin
        if (idx < 2 * LC) tag = poke ? "R8 R2 leader" : "R2 R9 leader";
        else if (idx < 2 * LC + 2) tag = "R3 mark";
        else tag = (e < s) ? "R6 R4 R10 data" : "R5 R4 R10 data";
        check(cnt == exp_iv[idx], tag, cnt, exp_iv[idx]);
        prev = tape_out; cnt = 0; idx++;
        if (idx == n) begin
          check(done == 1'b1, "R7 done at last edge", done, 1);
          check(busy == 1'b0, "R7 busy low at end", busy, 0);
        end else if (done) begin
          check(1'b0, "R5 early done", idx, n);
        end
      end
      if (cnt > 200) begin
        check(1'b0, "R4 interval timeout", cnt, exp_iv[idx]);
        idx = n;
      end
    end
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", done, 0);
  endtask

  initial begin
    logic lvl;
    repeat (3) @(negedge clk);
    check(tape_out == 1'b0, "R1 tape_out", tape_out, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check(mem_rd == 1'b0, "R1 mem_rd", mem_rd, 0);
    rst_n = 1'b1;
    // Table walk: back-to-back commands, each with its own leader (R9)
    for (int v = 0; v < 4; v++) run_cmd(VEC[v][15:8], VEC[v][7:0], v == 1);
    // Directed: reversed range sends one byte (R6)
    run_cmd(8'h80, 8'h01, 1'b0);
    // Directed: idle hold after done (R7)
    lvl = tape_out;
    repeat (6) @(negedge clk);
    check(tape_out == lvl, "R7 idle hold", tape_out, lvl);
    check(busy == 1'b0, "R7 idle busy", busy, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule